// File: doc/BRIEF.md
# Event Injection Field Validator

This block judges whether the description of an event queued for delivery to a guest at entry time is self-consistent. It reads a 32-bit interruption-information word, a 32-bit exception error code and a 32-bit instruction-length value. The validity rules depend on each other: the legal vectors depend on the event type, the error-code flag must agree with a fixed set of exception vectors, and the length range applies only to the software-originated types.

The caller presents all three words together with a one-cycle strobe. One clock later the block raises a one-cycle done pulse. A registered verdict and a bitmask are valid alongside the pulse. The bitmask names every rule that was broken, so several faults can be reported in the same evaluation. The verdict and mask hold their values until the next strobe.

Information-word layout used throughout: vector in bits 7:0, type in bits 10:8, deliver-error-code flag in bit 11, bits 30:12 reserved, armed (valid) flag in bit 31. Type codes: 0 external interrupt, 2 NMI, 3 hardware exception, 4 software interrupt, 5 privileged software exception, 6 software exception; 1 and 7 are reserved.

Top module: `evt_inject_check`

## Requirements
- R1: When bit 31 of the information word is 0, no rule is applied: after the strobe the mask is all zero and legal is 1, whatever the other inputs hold.
- R2: Mask bit 0 is set when the type field (bits 10:8) equals 1 or 7.
- R3: Mask bit 1 is set when the type is 2 (NMI) and the vector (bits 7:0) is not 2.
- R4: Mask bit 2 is set when the type is 3 (hardware exception) and the vector exceeds 31.
- R5: Mask bit 3 is set when bit 11 differs from the expected flag. The expected flag is 1 only for type 3 with vector 8, 10, 11, 12, 13, 14 or 17, and 0 otherwise.
- R6: Mask bit 4 is set when any of bits 30:12 of the information word is 1.
- R7: Mask bit 5 is set when bit 11 is 1 and any of bits 31:15 of the error code is 1.
- R8: Mask bit 6 is set when the type is 4, 5 or 6 and the instruction length lies outside 1..15 inclusive. For other types the length has no effect.
- R9: Legal is 1 exactly when no mask bit is set, and every broken rule sets its own bit in the same evaluation.
- R10: Done is 1 in the cycle after a strobe cycle and 0 otherwise. Mask and legal change only in the cycle after a strobe.
- R11: After reset, done is 0, the mask is 0 and legal is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inStrobe | input | 1 | Inputs are valid this cycle |
| infoWord | input | 32 | Interruption-information word |
| errCode | input | 32 | Exception error code |
| instrLen | input | 32 | Instruction length |
| doneOut | output | 1 | One-cycle pulse after a strobe |
| legalOut | output | 1 | Registered verdict |
| ruleMask | output | 7 | One bit per broken rule |

## Verification
The assertions assume that the three data words are stable and meaningful only in strobe cycles, and that the strobe is a plain level sampled at each edge, with no notion of back-pressure. The bench drives each word set on the falling edge and keeps it present for exactly one strobe cycle. It parks idle cycles between evaluations and changes the data words while the strobe is low, so the hold behaviour is exercised against non-strobe traffic. Reset is applied only at the start, so the properties never see a mid-run reset.

// File: rtl/evt_chk_pkg.sv
package evt_chk_pkg;
  localparam int WORD_W   = 32;
  localparam int VEC_W    = 8;
  localparam int RULE_CNT = 7;
  localparam int TYPE_LO  = 8;
  localparam int TYPE_W   = 3;
  localparam int FLAG_BIT = 11;
  localparam int RSV_LO   = 12;
  localparam int RSV_HI   = 30;
  localparam int ARM_BIT  = 31;
  localparam int ERR_HI_LO = 15;
  localparam int LEN_MIN  = 1;
  localparam int LEN_MAX  = 15;
  localparam int HW_VEC_MAX = 31;
  localparam int NMI_VEC  = 2;

  typedef enum logic [TYPE_W-1:0] {
    T_EXT    = 3'd0,
    T_RSV_A  = 3'd1,
    T_NMI    = 3'd2,
    T_HWEXC  = 3'd3,
    T_SWINT  = 3'd4,
    T_PRIVSW = 3'd5,
    T_SWEXC  = 3'd6,
    T_RSV_B  = 3'd7
  } evtType_e;

  typedef enum int {
    RULE_TYPE   = 0,
    RULE_NMI    = 1,
    RULE_HWVEC  = 2,
    RULE_FLAG   = 3,
    RULE_RSV    = 4,
    RULE_ERRHI  = 5,
    RULE_LEN    = 6
  } ruleIdx_e;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/evt_inject_ctrl.sv
module evt_inject_ctrl
  import evt_chk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inStrobe,
  output ctrlStrobes_t ctrl,
  output logic         doneOut
);
  logic doneQ;

  always_comb begin
    ctrl = '0;
    ctrl.capture = inStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= inStrobe;
  end

  assign doneOut = doneQ;

  // R10
  done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> doneOut);
  // R10
  done_only_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> !doneOut);
endmodule

// File: rtl/evt_inject_dp.sv
module evt_inject_dp
  import evt_chk_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int NRULES = RULE_CNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [W-1:0]      infoWord,
  input  logic [W-1:0]      errCode,
  input  logic [W-1:0]      instrLen,
  output logic              legalOut,
  output logic [NRULES-1:0] ruleMask
);
  localparam int RSV_W = RSV_HI - RSV_LO + 1;
  localparam int ERRHI_W = W - ERR_HI_LO;

  logic [VEC_W-1:0]  vecField;
  logic [TYPE_W-1:0] typeField;
  logic              flagBit;
  logic              armed;
  logic [RSV_W-1:0]  rsvField;
  logic [ERRHI_W-1:0] errHigh;
  logic              unusedErrLow;

  logic              wantFlag;
  logic              swOrigin;
  logic              lenInRange;
  logic [NRULES-1:0] rawBroken;
  logic [NRULES-1:0] nextMask;
  logic [NRULES-1:0] maskQ;
  logic              legalQ;

  function automatic logic carriesErrCode(input logic [VEC_W-1:0] v);
    case (v)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: carriesErrCode = 1'b1;
      default:                                        carriesErrCode = 1'b0;
    endcase
  endfunction

  assign vecField     = infoWord[VEC_W-1:0];
  assign typeField    = infoWord[TYPE_LO +: TYPE_W];
  assign flagBit      = infoWord[FLAG_BIT];
  assign armed        = infoWord[ARM_BIT];
  assign rsvField     = infoWord[RSV_HI:RSV_LO];
  assign errHigh      = errCode[W-1:ERR_HI_LO];
  assign unusedErrLow = ^errCode[ERR_HI_LO-1:0];

  always_comb begin
    wantFlag   = (typeField == T_HWEXC) && carriesErrCode(vecField);
    swOrigin   = (typeField == T_SWINT) || (typeField == T_PRIVSW) ||
                 (typeField == T_SWEXC);
    lenInRange = (instrLen >= W'(LEN_MIN)) && (instrLen <= W'(LEN_MAX));
  end

  always_comb begin
    rawBroken = '0;
    rawBroken[RULE_TYPE]  = (typeField == T_RSV_A) || (typeField == T_RSV_B);
    rawBroken[RULE_NMI]   = (typeField == T_NMI) && (vecField != VEC_W'(NMI_VEC));
    rawBroken[RULE_HWVEC] = (typeField == T_HWEXC) && (vecField > VEC_W'(HW_VEC_MAX));
    rawBroken[RULE_FLAG]  = (flagBit != wantFlag);
    rawBroken[RULE_RSV]   = |rsvField;
    rawBroken[RULE_ERRHI] = flagBit && (|errHigh);
    rawBroken[RULE_LEN]   = swOrigin && !lenInRange;
  end

  for (genvar i = 0; i < NRULES; i++) begin : g_gate
    assign nextMask[i] = armed & rawBroken[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      legalQ <= 1'b1;
    end else if (ctrl.capture) begin
      maskQ  <= nextMask;
      legalQ <= ~|nextMask;
    end
  end

  assign ruleMask = maskQ;
  assign legalOut = legalQ;

  // R1
  unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !infoWord[ARM_BIT]) |=> (ruleMask == '0) && legalOut);
  // R2
  reserved_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && infoWord[ARM_BIT] &&
     (infoWord[10:8] == 3'd1 || infoWord[10:8] == 3'd7)) |=> ruleMask[0] && !legalOut);
  // R9
  legal_vs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    legalOut == (ruleMask == '0));
  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(ruleMask) && $stable(legalOut));
endmodule

// File: rtl/evt_inject_check.sv
module evt_inject_check
  import evt_chk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inStrobe,
  input  logic [31:0]         infoWord,
  input  logic [31:0]         errCode,
  input  logic [31:0]         instrLen,
  output logic                doneOut,
  output logic                legalOut,
  output logic [RULE_CNT-1:0] ruleMask
);
  ctrlStrobes_t ctrl;

  evt_inject_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inStrobe (inStrobe),
    .ctrl     (ctrl),
    .doneOut  (doneOut)
  );

  evt_inject_dp #(.W(WORD_W), .NRULES(RULE_CNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .infoWord (infoWord),
    .errCode  (errCode),
    .instrLen (instrLen),
    .legalOut (legalOut),
    .ruleMask (ruleMask)
  );
endmodule

// File: tb/evt_inject_check_bench.sv
`timescale 1ns/1ps
module evt_inject_check_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inStrobe = 1'b0;
  logic [31:0] infoWord = '0;
  logic [31:0] errCode = '0;
  logic [31:0] instrLen = '0;
  logic        doneOut;
  logic        legalOut;
  logic [6:0]  ruleMask;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  evt_inject_check u_evt_inject_check (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .infoWord(infoWord),
    .errCode(errCode), .instrLen(instrLen), .doneOut(doneOut),
    .legalOut(legalOut), .ruleMask(ruleMask)
  );

  function automatic logic [31:0] mkInfo(input bit arm, input bit [2:0] t,
                                         input bit fl, input bit [7:0] v);
    return {arm, 19'd0, fl, t, v};
  endfunction

  function automatic logic [6:0] refMask(input logic [31:0] iw, input logic [31:0] ec,
                                         input logic [31:0] ln);
    logic [6:0] m = '0;
    logic [2:0] t = iw[10:8];
    logic [7:0] v = iw[7:0];
    logic want;
    if (!iw[31]) return '0;
    want = (t == 3) && (v == 8 || v == 10 || v == 11 || v == 12 ||
                        v == 13 || v == 14 || v == 17);
    m[0] = (t == 1) || (t == 7);
    m[1] = (t == 2) && (v != 2);
    m[2] = (t == 3) && (v > 31);
    m[3] = iw[11] != want;
    m[4] = iw[30:12] != 0;
    m[5] = iw[11] && (ec[31:15] != 0);
    m[6] = (t >= 4 && t <= 6) && (ln < 1 || ln > 15);
    return m;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Applies one evaluation and checks done, mask and legal one cycle later.
  task automatic evalOne(input string req, input logic [31:0] iw, input logic [31:0] ec,
                         input logic [31:0] ln);
    logic [6:0] em = refMask(iw, ec, ln);
    @(negedge clk);
    infoWord = iw; errCode = ec; instrLen = ln; inStrobe = 1'b1;
    @(negedge clk);
    inStrobe = 1'b0;
    check("R10", "done", doneOut, 1);
    check(req, "mask", ruleMask, em);
    check("R9", "legal", legalOut, em == 0);
  endtask

  task automatic testReset();
    check("R11", "done", doneOut, 0);
    check("R11", "mask", ruleMask, 0);
    check("R11", "legal", legalOut, 1);
  endtask

  task automatic testUnarmed();
    evalOne("R1", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0);
    evalOne("R1", 32'h0000_0F01, 32'hFFFF_0000, 32'd99);
  endtask

  task automatic testTypes();
    evalOne("R2", mkInfo(1, 3'd1, 0, 8'd0), 0, 1);
    evalOne("R2", mkInfo(1, 3'd7, 0, 8'd0), 0, 1);
    evalOne("R2", mkInfo(1, 3'd0, 0, 8'd200), 0, 0);
  endtask

  task automatic testNmi();
    evalOne("R3", mkInfo(1, 3'd2, 0, 8'd2), 0, 0);
    evalOne("R3", mkInfo(1, 3'd2, 0, 8'd3), 0, 0);
  endtask

  task automatic testHwVec();
    evalOne("R4", mkInfo(1, 3'd3, 0, 8'd31), 0, 0);
    evalOne("R4", mkInfo(1, 3'd3, 0, 8'd32), 0, 0);
    evalOne("R4", mkInfo(1, 3'd3, 0, 8'd255), 0, 0);
  endtask

  task automatic testFlag();
    for (int v = 0; v < 32; v++) begin
      logic fl = (v == 8 || v == 10 || v == 11 || v == 12 || v == 13 ||
                  v == 14 || v == 17);
      evalOne("R5", mkInfo(1, 3'd3, fl, 8'(v)), 0, 0);
      evalOne("R5", mkInfo(1, 3'd3, !fl, 8'(v)), 0, 0);
    end
    evalOne("R5", mkInfo(1, 3'd0, 1, 8'd14), 0, 0);
    evalOne("R5", mkInfo(1, 3'd6, 1, 8'd13), 0, 3);
  endtask

  task automatic testRsvBits();
    for (int b = 12; b <= 30; b += 6)
      evalOne("R6", mkInfo(1, 3'd0, 0, 8'd0) | (32'd1 << b), 0, 0);
  endtask

  task automatic testErrHigh();
    evalOne("R7", mkInfo(1, 3'd3, 1, 8'd13), 32'h0000_7FFF, 0);
    evalOne("R7", mkInfo(1, 3'd3, 1, 8'd13), 32'h0000_8000, 0);
    evalOne("R7", mkInfo(1, 3'd3, 0, 8'd3), 32'hFFFF_0000, 0);
  endtask

  task automatic testLength();
    for (int t = 4; t <= 6; t++) begin
      evalOne("R8", mkInfo(1, 3'(t), 0, 8'd3), 0, 0);
      evalOne("R8", mkInfo(1, 3'(t), 0, 8'd3), 0, 1);
      evalOne("R8", mkInfo(1, 3'(t), 0, 8'd3), 0, 15);
      evalOne("R8", mkInfo(1, 3'(t), 0, 8'd3), 0, 16);
      evalOne("R8", mkInfo(1, 3'(t), 0, 8'd3), 0, 32'h1000_0005);
    end
    evalOne("R8", mkInfo(1, 3'd3, 0, 8'd3), 0, 0);
  endtask

  task automatic testMulti();
    evalOne("R9", {1'b1, 19'h4, 1'b1, 3'd7, 8'd9}, 32'h8000_0000, 0);
    evalOne("R9", mkInfo(1, 3'd2, 1, 8'd40), 32'hFFFF_FFFF, 0);
  endtask

  task automatic testHold();
    evalOne("R10", mkInfo(1, 3'd2, 0, 8'd5), 0, 0);
    @(negedge clk);
    infoWord = mkInfo(1, 3'd0, 0, 8'd0); errCode = 0; instrLen = 0;
    repeat (3) @(negedge clk);
    check("R10", "done idle", doneOut, 0);
    check("R10", "mask held", ruleMask, 7'b000_0010);
    check("R10", "legal held", legalOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnarmed();
    testTypes();
    testNmi();
    testHwVec();
    testFlag();
    testRsvBits();
    testErrHigh();
    testLength();
    testMulti();
    testHold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule